// File: doc/BRIEF.md
# DMA Write Lane Adapter

This stage sits in the datapath of one DMA channel, between the point where an item has been read from the source port and the 32-bit destination port. For each accepted item it produces the word to drive on the write data bus, the transfer size code and the destination address aligned to that size. An item that is wider than the destination is cut down to its low bits. An item that is narrower than the destination is padded with zeros in its upper bits.

A write narrower than a word is then copied onto every byte lane of the bus. A halfword appears in both halves, and a byte appears in all four lanes. Because of this, a slave that ignores the size signal and always latches the full 32 bits still stores the intended value.

All three outputs are registered. They appear one cycle after the read data is accepted and hold until the next item is accepted. Every accepted read gives exactly one write.

Top module: `dma_lane_adapter`

## Requirements
- R1: After reset `wr_valid` is 0 and `wr_data`, `wr_size` and `wr_addr` are all 0.
- R2: For each cycle with `rd_valid` high, `wr_valid` is high in the next cycle. For each cycle with `rd_valid` low, `wr_valid` is low in the next cycle. Each read therefore gives exactly one write.
- R3: When the source width exceeds the destination width, only the low destination-width bits of `rd_data` are used. A 32-bit source to an 8-bit destination uses bits [7:0]. A 32-bit or 16-bit source to a 16-bit destination uses bits [15:0].
- R4: When the source width is below the destination width, the bits of `rd_data` above the source width are ignored and read as zero.
- R5: When source and destination widths are equal at 32 bits, `wr_data` equals `rd_data` unchanged.
- R6: A halfword write drives its 16-bit value on both bits [31:16] and bits [15:0]. For example, 0xABCD is driven as 0xABCDABCD.
- R7: A byte write drives its 8-bit value on all four byte lanes. For example, 0xAB is driven as 0xABABABAB.
- R8: `wr_size` encodes the destination width as 0 for 8 bits, 1 for 16 bits and 2 for 32 bits, and is never 3.
- R9: The width codes on `src_width` and `dst_width` are 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. Code 3 is treated as 32 bits.
- R10: `wr_addr` is `dst_addr` aligned to the destination size. It is unchanged for bytes, has bit 0 cleared for halfwords, and has bits [1:0] cleared for words.
- R11: While `rd_valid` is low, `wr_data`, `wr_size` and `wr_addr` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read item accepted this cycle |
| src_width | input | 2 | Source item width code |
| dst_width | input | 2 | Destination width code |
| rd_data | input | 32 | Word returned by the source read |
| dst_addr | input | ADDR_W | Destination byte address |
| wr_valid | output | 1 | Destination write presented |
| wr_data | output | 32 | Write data, lane-replicated |
| wr_size | output | 2 | Transfer size code |
| wr_addr | output | ADDR_W | Size-aligned destination address |

## Verification
Width matching and lane replication both act on the same item in the same cycle. A narrow source feeding a wider but sub-word destination exercises both at once: for example, a byte into a halfword destination must be zero-extended and then duplicated, giving 0x00AB00AB. Wide-to-narrow cases such as a word into a byte destination combine truncation with four-way copying. The bench provokes these combinations through its vector table, including rows with dirty upper bits on `rd_data` and the reserved width code. It judges each row by the exact 32-bit word, size code and aligned address one cycle after acceptance. Back-to-back accepted items then confirm that one output is produced per item with no stale data.

// File: rtl/dla_pkg.sv
package dla_pkg;
  localparam int unsigned DLA_DATA_W = 32;
  localparam int unsigned DLA_LANES  = DLA_DATA_W / 8;

  // Width encoding doubles as the bus size code (R8, R9)
  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_HALF = 2'd1,
    WID_WORD = 2'd2
  } wid_e;

  // Reserved code 3 maps to a full word (R9)
  function automatic wid_e decode_wid(input logic [1:0] code);
    return (code == 2'd3) ? WID_WORD : wid_e'(code);
  endfunction

  function automatic wid_e narrower(input wid_e a, input wid_e b);
    return (a < b) ? a : b;
  endfunction

  // Keep only the low bits of width w, zero above (R3, R4)
  function automatic logic [DLA_DATA_W-1:0] keep_low(input logic [DLA_DATA_W-1:0] d,
                                                     input wid_e w);
    logic [DLA_DATA_W-1:0] r;
    r = '0;
    case (w)
      WID_BYTE: r[7:0]  = d[7:0];
      WID_HALF: r[15:0] = d[15:0];
      default:  r       = d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dla_width_decode.sv
module dla_width_decode
  import dla_pkg::*;
(
  input  logic [1:0] src_code,
  input  logic [1:0] dst_code,
  output wid_e       src_w,
  output wid_e       dst_w,
  output logic [1:0] size_code
);
  assign src_w     = decode_wid(src_code);   // R9
  assign dst_w     = decode_wid(dst_code);   // R9
  assign size_code = 2'(dst_w);              // R8
endmodule

// File: rtl/dla_lane_resize.sv
module dla_lane_resize
  import dla_pkg::*;
(
  input  logic [DLA_DATA_W-1:0] rd_data,
  input  wid_e                  src_w,
  input  wid_e                  dst_w,
  output logic [DLA_DATA_W-1:0] lanes
);
  logic [DLA_DATA_W-1:0] item;

  // Fit item to the smaller of the two widths: truncate or zero-extend (R3, R4, R5)
  assign item = keep_low(rd_data, narrower(src_w, dst_w));

  // Copy narrow items onto every lane (R6, R7)
  for (genvar i = 0; i < DLA_LANES; i++) begin : g_lane
    localparam int HSEL = i % 2;
    assign lanes[8*i +: 8] = (dst_w == WID_BYTE) ? item[7:0] :
                             (dst_w == WID_HALF) ? item[8*HSEL +: 8] :
                                                   item[8*i +: 8];
  end
endmodule

// File: rtl/dla_addr_align.sv
module dla_addr_align
  import dla_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  wid_e              dst_w,
  output logic [ADDR_W-1:0] addr_out
);
  // R10: clear the low address bits below the transfer size
  always_comb begin
    addr_out = addr_in;
    case (dst_w)
      WID_HALF: addr_out[0]   = 1'b0;
      WID_WORD: addr_out[1:0] = 2'b00;
      default:  ;
    endcase
  end
endmodule

// File: rtl/dla_out_stage.sv
module dla_out_stage
  import dla_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [DLA_DATA_W-1:0] data_in,
  input  logic [1:0]            size_in,
  input  logic [ADDR_W-1:0]     addr_in,
  output logic                  wr_valid,
  output logic [DLA_DATA_W-1:0] wr_data,
  output logic [1:0]            wr_size,
  output logic [ADDR_W-1:0]     wr_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin          // R1
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_size  <= 2'd0;
      wr_addr  <= '0;
    end else begin
      wr_valid <= load;        // R2
      if (load) begin          // R11: hold otherwise
        wr_data <= data_in;
        wr_size <= size_in;
        wr_addr <= addr_in;
      end
    end
  end

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> wr_valid);                                                    // R2
  AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !wr_valid);                                                  // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(wr_data) && $stable(wr_size) && $stable(wr_addr))); // R11
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_size != 2'd3);                                                      // R8
  AST_BYTE_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_size == 2'd0) |-> (wr_data[31:24] == wr_data[7:0] &&
      wr_data[23:16] == wr_data[7:0] && wr_data[15:8] == wr_data[7:0]));   // R7
  AST_HALF_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_size == 2'd1) |-> (wr_data[31:16] == wr_data[15:0]));  // R6
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_size == 2'd2) |-> (wr_addr[1:0] == 2'b00));            // R10
  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_size == 2'd1) |-> (wr_addr[0] == 1'b0));               // R10
endmodule

// File: rtl/dma_lane_adapter.sv
module dma_lane_adapter
  import dla_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_valid,
  input  logic [1:0]            src_width,
  input  logic [1:0]            dst_width,
  input  logic [DLA_DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0]     dst_addr,
  output logic                  wr_valid,
  output logic [DLA_DATA_W-1:0] wr_data,
  output logic [1:0]            wr_size,
  output logic [ADDR_W-1:0]     wr_addr
);
  wid_e                  src_w;
  wid_e                  dst_w;
  logic [1:0]            size_c;
  logic [DLA_DATA_W-1:0] lanes_c;
  logic [ADDR_W-1:0]     addr_c;

  dla_width_decode u_dec (
    .src_code (src_width),
    .dst_code (dst_width),
    .src_w    (src_w),
    .dst_w    (dst_w),
    .size_code(size_c)
  );

  dla_lane_resize u_resize (
    .rd_data(rd_data),
    .src_w  (src_w),
    .dst_w  (dst_w),
    .lanes  (lanes_c)
  );

  dla_addr_align #(.ADDR_W(ADDR_W)) u_align (
    .addr_in (dst_addr),
    .dst_w   (dst_w),
    .addr_out(addr_c)
  );

  dla_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rd_valid),
    .data_in (lanes_c),
    .size_in (size_c),
    .addr_in (addr_c),
    .wr_valid(wr_valid),
    .wr_data (wr_data),
    .wr_size (wr_size),
    .wr_addr (wr_addr)
  );
endmodule

// File: tb/dma_lane_adapter_tb.sv
module dma_lane_adapter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic [1:0]  src_width = 2'd0;
  logic [1:0]  dst_width = 2'd0;
  logic [31:0] rd_data = '0;
  logic [31:0] dst_addr = '0;
  logic        wr_valid;
  logic [31:0] wr_data;
  logic [1:0]  wr_size;
  logic [31:0] wr_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_lane_adapter #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid),
    .src_width(src_width), .dst_width(dst_width),
    .rd_data(rd_data), .dst_addr(dst_addr),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_size(wr_size), .wr_addr(wr_addr)
  );

  typedef struct packed {
    logic [1:0]  src;
    logic [1:0]  dst;
    logic [31:0] rd;
    logic [31:0] addr;
    logic [31:0] edata;
    logic [1:0]  esize;
    logic [31:0] eaddr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 2'd0, 32'h12345678, 32'h1003, 32'h78787878, 2'd0, 32'h1003}, // R3 R7
    '{2'd2, 2'd1, 32'h12345678, 32'h1003, 32'h56785678, 2'd1, 32'h1002}, // R3 R6 R10
    '{2'd2, 2'd2, 32'hDEADBEEF, 32'h2007, 32'hDEADBEEF, 2'd2, 32'h2004}, // R5 R10
    '{2'd0, 2'd2, 32'hFFFFFFAB, 32'h0010, 32'h000000AB, 2'd2, 32'h0010}, // R4
    '{2'd1, 2'd2, 32'hFFFFABCD, 32'h0022, 32'h0000ABCD, 2'd2, 32'h0020}, // R4
    '{2'd0, 2'd1, 32'h123456AB, 32'h0005, 32'h00AB00AB, 2'd1, 32'h0004}, // R4 R6
    '{2'd1, 2'd1, 32'h1234ABCD, 32'h0002, 32'hABCDABCD, 2'd1, 32'h0002}, // R6
    '{2'd0, 2'd0, 32'h000000AB, 32'h0003, 32'hABABABAB, 2'd0, 32'h0003}, // R7
    '{2'd3, 2'd3, 32'hCAFEF00D, 32'h000B, 32'hCAFEF00D, 2'd2, 32'h0008}, // R9
    '{2'd3, 2'd0, 32'h11223344, 32'h0001, 32'h44444444, 2'd0, 32'h0001}, // R9 R3
    '{2'd1, 2'd0, 32'h9999ABCD, 32'h0006, 32'hCDCDCDCD, 2'd0, 32'h0006}, // R3
    '{2'd1, 2'd3, 32'hFFFF1234, 32'h0007, 32'h00001234, 2'd2, 32'h0004}  // R9 R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic present(input vec_t v);
    @(negedge clk);
    rd_valid  = 1'b1;
    src_width = v.src;
    dst_width = v.dst;
    rd_data   = v.rd;
    dst_addr  = v.addr;
  endtask

  task automatic check_out(input vec_t v, input int idx);
    check($sformatf("R2 valid vec %0d", idx), {31'b0, wr_valid}, 32'd1);
    check($sformatf("R3/R4/R5/R6/R7/R9 data vec %0d", idx), wr_data, v.edata);
    check($sformatf("R8 size vec %0d", idx), {30'b0, wr_size}, {30'b0, v.esize});
    check($sformatf("R10 addr vec %0d", idx), wr_addr, v.eaddr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 valid", {31'b0, wr_valid}, 32'd0);
    check("R1 data", wr_data, 32'd0);
    check("R1 size", {30'b0, wr_size}, 32'd0);
    check("R1 addr", wr_addr, 32'd0);

    // Vector table, one item at a time
    for (int i = 0; i < NV; i++) begin
      present(VEC[i]);
      @(negedge clk);
      rd_valid = 1'b0;
      check_out(VEC[i], i);
    end

    // R11: idle inputs change, outputs hold; R2 no extra write
    present(VEC[6]);
    @(negedge clk);
    rd_valid  = 1'b0;
    rd_data   = 32'h55AA55AA;
    dst_width = 2'd2;
    src_width = 2'd0;
    dst_addr  = 32'hFFF1;
    @(negedge clk);
    check("R2 no write while idle", {31'b0, wr_valid}, 32'd0);
    check("R11 data held", wr_data, 32'hABCDABCD);
    check("R11 size held", {30'b0, wr_size}, 32'd1);
    check("R11 addr held", wr_addr, 32'h0002);

    // R2: back-to-back items each produce their own write
    present(VEC[0]);
    present(VEC[7]);
    check_out(VEC[0], 100);
    @(negedge clk);
    rd_valid = 1'b0;
    check_out(VEC[7], 101);
    @(negedge clk);
    check("R2 single write per read", {31'b0, wr_valid}, 32'd0);

    // R1: reset mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 data after re-reset", wr_data, 32'd0);
    check("R1 valid after re-reset", {31'b0, wr_valid}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule